// File: doc/BRIEF.md
# Windowed Mode-Switch Decision Unit

This unit decides when a reconfigurable core should move to another of its four operating modes. Each cycle the pipeline reports how many instructions retired, and the unit adds these counts up into fixed windows of retired work. At the close of each window it reads four externally computed efficiency scores, one per mode, each a fixed-point estimate of instructions-per-second squared per watt. The mode with the highest score becomes that window's recommendation.

The unit keeps the recommendations of the most recent windows. After a fixed number of windows it holds a vote over them. The winning mode is requested only when it differs from the present mode and its score beats the present mode's score by a fixed relative margin. This filters out short-lived phases and avoids switching back and forth on small gains. The unit issues no decision while a reconfiguration is still in progress, but it keeps counting windows during that time.

Top module: `msd_switch_unit`

## Requirements
- R1: The per-cycle retired count `ret_cnt` is added up. A window closes in the cycle where the running total reaches WINDOW (512). Any excess beyond 512 carries into the next window.
- R2: Each window's recommendation is the mode with the highest score. The scores of all modes are sampled in the closing cycle. Mode m's score sits at `scores[16*m+15:16*m]`. Among equal scores the lowest mode code wins. The codes are 0 Average, 1 Narrow, 2 Wide and 3 Small.
- R3: The last DEPTH (4) recommendations are kept. The vote target is the mode that occurs most often among them, counting the recommendation of the closing window.
- R4: A decision is evaluated only at every DEPTH-th window close, which is every 2048 retired instructions. No request appears at any other time.
- R5: On a tie in the vote, the current mode wins if it is among the tied modes. Otherwise the most recent recommendation among the tied modes wins.
- R6: A switch needs 20 × target score > 21 × current score, using the scores of the closing window. Equality gives no switch.
- R7: When `reconf_busy` is high in the decision cycle, no request is issued. Window counting continues, so the next decision comes DEPTH windows later.
- R8: A request is issued only when the target differs from the current mode. `req_valid` then pulses for one cycle with `req_mode` set to the target, and `cur_mode` takes the target in the same cycle. Otherwise `cur_mode` holds.
- R9: Reset sets `cur_mode` to Average, clears `req_valid`, and clears the window total and the window position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ret_cnt | input | 3 | Instructions retired this cycle |
| scores | input | 64 | Four packed 16-bit efficiency scores, mode 0 lowest |
| reconf_busy | input | 1 | Reconfiguration in progress; blocks decisions |
| req_valid | output | 1 | One-cycle switch request strobe |
| req_mode | output | 2 | Requested target mode |
| cur_mode | output | 2 | Mode the unit believes the core is in |

## Verification
All results are registered once. `req_valid`, `req_mode` and `cur_mode` change at the clock edge where the window-closing count is presented, so they are due one cycle after that stimulus. The bench drives inputs on the falling edge. It tracks the retired total itself, so it knows in which cycle each window closes, and it samples the outputs at the falling edge right after that closing edge. In every other cycle of a window it confirms that no request appears. The expected recommendation, vote and margin outcome come from an arithmetic model in the bench that uses loops and integer products.

// File: rtl/msd_pkg.sv
package msd_pkg;
  localparam int NUM_MODES = 4;
  localparam int MODE_W    = 2;

  typedef enum logic [MODE_W-1:0] {
    MODE_AVG    = 2'd0,
    MODE_NARROW = 2'd1,
    MODE_WIDE   = 2'd2,
    MODE_SMALL  = 2'd3
  } mode_e;
endpackage

// File: rtl/msd_window_ctr.sv
module msd_window_ctr #(
  parameter int WINDOW = 512,
  parameter int DEPTH  = 4,
  parameter int RET_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [RET_W-1:0] ret_cnt,
  output logic             win_close,
  output logic             dec_point
);
  localparam int ACC_W = $clog2(WINDOW + (1 << RET_W));
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] sum;
  logic [IDX_W-1:0] idx_q;

  always_comb begin
    sum       = acc_q + ACC_W'(ret_cnt);
    win_close = (sum >= ACC_W'(WINDOW));
    dec_point = win_close && (idx_q == IDX_W'(DEPTH - 1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= '0;
      idx_q <= '0;
    end else if (win_close) begin
      acc_q <= sum - ACC_W'(WINDOW);
      idx_q <= dec_point ? '0 : idx_q + IDX_W'(1);
    end else begin
      acc_q <= sum;
    end
  end
endmodule

// File: rtl/msd_best_pick.sv
module msd_best_pick
  import msd_pkg::*;
#(
  parameter int SCORE_W = 16
) (
  input  logic [NUM_MODES*SCORE_W-1:0] scores,
  output mode_e                        best
);
  logic [SCORE_W-1:0] best_s;

  always_comb begin
    best   = MODE_AVG;
    best_s = scores[SCORE_W-1:0];
    for (int m = 1; m < NUM_MODES; m++) begin
      if (scores[m*SCORE_W +: SCORE_W] > best_s) begin
        best_s = scores[m*SCORE_W +: SCORE_W];
        best   = mode_e'(MODE_W'(m));
      end
    end
  end
endmodule

// File: rtl/msd_vote.sv
module msd_vote
  import msd_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  push,
  input  mode_e rec,
  input  mode_e cur_mode,
  output mode_e vote_mode
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  mode_e               hist_q [DEPTH];
  mode_e               hist_n [DEPTH];
  logic [CNT_W-1:0]    cnt    [NUM_MODES];
  logic [CNT_W-1:0]    top_cnt;
  logic [NUM_MODES-1:0] tied;
  logic                found;

  assign hist_n[0] = rec;
  for (genvar i = 1; i < DEPTH; i++) begin : g_shift
    assign hist_n[i] = hist_q[i-1];
  end

  always_comb begin
    for (int m = 0; m < NUM_MODES; m++) begin
      cnt[m] = '0;
      for (int i = 0; i < DEPTH; i++) begin
        if (hist_n[i] == mode_e'(MODE_W'(m))) cnt[m] = cnt[m] + CNT_W'(1);
      end
    end
    top_cnt = '0;
    for (int m = 0; m < NUM_MODES; m++) begin
      if (cnt[m] > top_cnt) top_cnt = cnt[m];
    end
    for (int m = 0; m < NUM_MODES; m++) begin
      tied[m] = (cnt[m] == top_cnt);
    end
    found     = 1'b0;
    vote_mode = cur_mode;
    if (!tied[cur_mode]) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (!found && tied[hist_n[i]]) begin
          vote_mode = hist_n[i];
          found     = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) hist_q[i] <= MODE_AVG;
    end else if (push) begin
      for (int i = 0; i < DEPTH; i++) hist_q[i] <= hist_n[i];
    end
  end
endmodule

// File: rtl/msd_switch_unit.sv
module msd_switch_unit
  import msd_pkg::*;
#(
  parameter int WINDOW     = 512,
  parameter int DEPTH      = 4,
  parameter int RET_W      = 3,
  parameter int SCORE_W    = 16,
  parameter int MARGIN_NUM = 21,
  parameter int MARGIN_DEN = 20
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [RET_W-1:0]             ret_cnt,
  input  logic [NUM_MODES*SCORE_W-1:0] scores,
  input  logic                         reconf_busy,
  output logic                         req_valid,
  output logic [MODE_W-1:0]            req_mode,
  output logic [MODE_W-1:0]            cur_mode
);
  localparam int PROD_W = SCORE_W + $clog2(MARGIN_NUM + MARGIN_DEN + 1) + 1;

  function automatic logic [SCORE_W-1:0] score_of(
    input logic [NUM_MODES*SCORE_W-1:0] s,
    input mode_e                        m
  );
    return s[int'(m)*SCORE_W +: SCORE_W];
  endfunction

  function automatic logic clears_margin(
    input logic [SCORE_W-1:0] tgt,
    input logic [SCORE_W-1:0] cur
  );
    logic [PROD_W-1:0] lhs;
    logic [PROD_W-1:0] rhs;
    lhs = PROD_W'(MARGIN_DEN) * PROD_W'(tgt);
    rhs = PROD_W'(MARGIN_NUM) * PROD_W'(cur);
    return lhs > rhs;
  endfunction

  logic  win_close;
  logic  dec_point;
  logic  margin_ok;
  logic  switch_go;
  mode_e rec_mode;
  mode_e vote_mode;
  mode_e cur_q;
  mode_e req_q;
  logic  req_valid_q;

  msd_window_ctr #(
    .WINDOW (WINDOW),
    .DEPTH  (DEPTH),
    .RET_W  (RET_W)
  ) u_win (
    .clk       (clk),
    .rst_n     (rst_n),
    .ret_cnt   (ret_cnt),
    .win_close (win_close),
    .dec_point (dec_point)
  );

  msd_best_pick #(
    .SCORE_W (SCORE_W)
  ) u_pick (
    .scores (scores),
    .best   (rec_mode)
  );

  msd_vote #(
    .DEPTH (DEPTH)
  ) u_vote (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (win_close),
    .rec       (rec_mode),
    .cur_mode  (cur_q),
    .vote_mode (vote_mode)
  );

  assign margin_ok = clears_margin(score_of(scores, vote_mode), score_of(scores, cur_q));
  assign switch_go = dec_point && !reconf_busy && (vote_mode != cur_q) && margin_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q       <= MODE_AVG;
      req_q       <= MODE_AVG;
      req_valid_q <= 1'b0;
    end else begin
      req_valid_q <= switch_go;
      if (switch_go) begin
        cur_q <= vote_mode;
        req_q <= vote_mode;
      end
    end
  end

  assign req_valid = req_valid_q;
  assign req_mode  = req_q;
  assign cur_mode  = cur_q;
endmodule

// File: rtl/msd_switch_chk.sv
module msd_switch_chk
  import msd_pkg::*;
#(
  parameter int SCORE_W    = 16,
  parameter int DEPTH      = 4,
  parameter int MARGIN_NUM = 21,
  parameter int MARGIN_DEN = 20
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         reconf_busy,
  input logic [NUM_MODES*SCORE_W-1:0] scores,
  input logic                         req_valid,
  input logic [MODE_W-1:0]            req_mode,
  input logic [MODE_W-1:0]            cur_mode,
  input logic                         win_close,
  input logic                         dec_point
);
  localparam int CW = SCORE_W + 8;

  logic [NUM_MODES*SCORE_W-1:0] scores_q;
  logic [MODE_W-1:0]            cur_prev;
  logic [7:0]                   since_dec;
  logic [CW-1:0]                tgt_prod;
  logic [CW-1:0]                cur_prod;

  always_ff @(posedge clk) begin
    scores_q <= scores;
    cur_prev <= cur_mode;
    if (!rst_n) since_dec <= '0;
    else if (win_close) since_dec <= dec_point ? 8'd0 : since_dec + 8'd1;
  end

  always_comb begin
    tgt_prod = CW'(MARGIN_DEN) * CW'(scores_q[int'(req_mode)*SCORE_W +: SCORE_W]);
    cur_prod = CW'(MARGIN_NUM) * CW'(scores_q[int'(cur_prev)*SCORE_W +: SCORE_W]);
  end

  assert_busy_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> !$past(reconf_busy));

  assert_req_at_decision_R4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> $past(dec_point));

  assert_decision_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dec_point |-> (win_close && since_dec == 8'(DEPTH - 1)));

  assert_req_moves_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_mode == cur_mode) && (cur_mode != $past(cur_mode)));

  assert_mode_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> $stable(cur_mode));

  assert_margin_met_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (tgt_prod > cur_prod));
endmodule

bind msd_switch_unit msd_switch_chk #(
  .SCORE_W    (SCORE_W),
  .DEPTH      (DEPTH),
  .MARGIN_NUM (MARGIN_NUM),
  .MARGIN_DEN (MARGIN_DEN)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reconf_busy (reconf_busy),
  .scores      (scores),
  .req_valid   (req_valid),
  .req_mode    (req_mode),
  .cur_mode    (cur_mode),
  .win_close   (win_close),
  .dec_point   (dec_point)
);

// File: tb/msd_switch_unit_tb.sv
`timescale 1ns/1ps
module msd_switch_unit_tb;
  localparam int WIN = 512;
  localparam int HD  = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  ret_cnt = '0;
  logic [63:0] scores = '0;
  logic        reconf_busy = 1'b0;
  logic        req_valid;
  logic [1:0]  req_mode;
  logic [1:0]  cur_mode;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  int acc_m = 0;
  int widx_m = 0;
  int cur_m = 0;
  int hist_m [HD];

  always #2.5 clk = ~clk;

  msd_switch_unit u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .ret_cnt     (ret_cnt),
    .scores      (scores),
    .reconf_busy (reconf_busy),
    .req_valid   (req_valid),
    .req_mode    (req_mode),
    .cur_mode    (cur_mode)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [63:0] pk(input int a, input int n, input int w, input int s);
    return {16'(s), 16'(w), 16'(n), 16'(a)};
  endfunction

  function automatic int sc_of(input logic [63:0] sc, input int m);
    return int'(sc[m*16 +: 16]);
  endfunction

  function automatic int best_of(input logic [63:0] sc);
    int b = 0;
    for (int m = 1; m < 4; m++) if (sc_of(sc, m) > sc_of(sc, b)) b = m;
    return b;
  endfunction

  function automatic int vote_of();
    int cnt [4];
    int mx = 0;
    for (int m = 0; m < 4; m++) cnt[m] = 0;
    for (int j = 0; j < HD; j++) cnt[hist_m[j]]++;
    for (int m = 0; m < 4; m++) if (cnt[m] > mx) mx = cnt[m];
    if (cnt[cur_m] == mx) return cur_m;
    for (int j = 0; j < HD; j++) if (cnt[hist_m[j]] == mx) return hist_m[j];
    return cur_m;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    ret_cnt = '0;
    reconf_busy = 1'b0;
    repeat (2) @(negedge clk);
    check(req_valid == 1'b0, "R9 req_valid in reset", int'(req_valid), 0);
    check(cur_mode == 2'd0, "R9 cur_mode in reset", int'(cur_mode), 0);
    rst_n = 1'b1;
    acc_m = 0;
    widx_m = 0;
    cur_m = 0;
    for (int j = 0; j < HD; j++) hist_m[j] = 0;
  endtask

  task automatic run_window(input logic [63:0] sc, input bit bsy, input int step, input string tag);
    bit closed = 1'b0;
    bit spurious = 1'b0;
    bit exp_req = 1'b0;
    int tgt = 0;
    bit is_dec;
    scores = sc;
    reconf_busy = bsy;
    while (!closed) begin
      ret_cnt = 3'(step);
      acc_m += step;
      if (acc_m >= WIN) begin
        acc_m -= WIN;
        closed = 1'b1;
      end
      @(posedge clk);
      @(negedge clk);
      if (!closed && req_valid) spurious = 1'b1;
    end
    ret_cnt = '0;
    for (int j = HD - 1; j > 0; j--) hist_m[j] = hist_m[j-1];
    hist_m[0] = best_of(sc);
    widx_m++;
    is_dec = (widx_m == HD);
    if (is_dec) begin
      widx_m = 0;
      tgt = vote_of();
      if (tgt != cur_m && !bsy && 20 * sc_of(sc, tgt) > 21 * sc_of(sc, cur_m)) begin
        exp_req = 1'b1;
        cur_m = tgt;
      end
    end
    check(!spurious, "R1 no request inside window", int'(spurious), 0);
    check(req_valid == exp_req, is_dec ? {tag, " req_valid"} : "R4 req_valid off-decision",
          int'(req_valid), int'(exp_req));
    if (exp_req) check(req_mode == 2'(tgt), {tag, " req_mode"}, int'(req_mode), tgt);
    check(cur_mode == 2'(cur_m), {tag, " cur_mode"}, int'(cur_mode), cur_m);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog all-R actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R3 R8: unanimous Narrow, large margin
    for (int k = 0; k < 4; k++) run_window(pk(1000, 2000, 500, 500), 1'b0, 4, "R3 R8 unanimous");
    // R3: one transient Wide window, majority stays with current Narrow; step 3 carries (R1)
    run_window(pk(100, 200, 3000, 100), 1'b0, 3, "R3 transient");
    for (int k = 0; k < 3; k++) run_window(pk(1000, 3000, 500, 500), 1'b0, 3, "R3 R1 transient");
    // R5: 2-2 tie Wide/Small, current Narrow not tied -> most recent Small
    for (int k = 0; k < 2; k++) begin
      run_window(pk(100, 1000, 3000, 200), 1'b0, 5, "R5 tie recent");
      run_window(pk(100, 1000, 200, 3000), 1'b0, 5, "R5 tie recent");
    end
    // R5: tie includes current Small -> stay
    run_window(pk(5000, 100, 100, 100), 1'b0, 7, "R5 tie current");
    run_window(pk(100, 100, 100, 5000), 1'b0, 7, "R5 tie current");
    run_window(pk(100, 100, 100, 5000), 1'b0, 7, "R5 tie current");
    run_window(pk(5000, 100, 100, 100), 1'b0, 7, "R5 tie current");
    // R6: exact 5% equality -> no switch
    for (int k = 0; k < 4; k++) run_window(pk(2100, 100, 100, 2000), 1'b0, 4, "R6 equal margin");
    // R6: just above -> switch to Average
    for (int k = 0; k < 4; k++) run_window(pk(2101, 100, 100, 2000), 1'b0, 4, "R6 above margin");
    // R7: busy at decision blocks
    for (int k = 0; k < 4; k++) run_window(pk(100, 4000, 100, 100), k == 3, 4, "R7 busy blocks");
    // R7: busy mid-history only, decision four windows later proceeds
    for (int k = 0; k < 4; k++) run_window(pk(100, 4000, 100, 100), k == 1, 6, "R7 busy earlier");
    // R2: equal top scores Wide/Small -> lower code Wide
    for (int k = 0; k < 4; k++) run_window(pk(100, 100, 4000, 4000), 1'b0, 4, "R2 score tie");
    // R9 R1: reset in the middle of a window clears the total
    for (int k = 0; k < 100; k++) begin
      ret_cnt = 3'd4;
      @(posedge clk);
      @(negedge clk);
    end
    do_reset();
    for (int k = 0; k < 4; k++) run_window(pk(1000, 2000, 100, 100), 1'b0, 4, "R9 R1 after reset");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule